// File: doc/BRIEF.md
# Prefixed Instruction Pre-Decoder

This block sits at the front of an instruction decoder and watches a stream of 32-bit instruction words arriving in program order. A word whose primary opcode is 9 is a vector-style prefix, and a word whose primary opcode is 1 is a wide-immediate prefix. Either kind is held until the next word arrives. The two words then leave together as one 64-bit record. Any other word leaves alone as a plain 32-bit instruction. Each record carries a space code, a coarse class of the base-opcode word, and a trap cause. The space code tells later stages which encoding area the pair belongs to.

The space of an opcode-9 pair depends on four things: prefix bits 6 and 7, whether prefix bits 8-31 are all zero, and bit 32 (the first bit of the suffix). Reserved areas and the not-yet-defined single-prefix areas raise the illegal-instruction flag. So does a prefix whose suffix is itself a prefix, which would make a 96-bit instruction. So does a vector prefix on a base-space suffix that makes no sense to repeat. Bits are numbered MSB-0 across the pair: bit n of a word is `in_word[31-n]`. The primary opcode (PO) is bits 0-5 (`[31:26]`). The extended opcode (XO) is bits 21-30 (`[10:1]`).

Top module: `vpfx_predecode`

## Requirements
- R1: Under synchronous active-low reset, `out_valid` is 0 and the block waits for a fresh word. A prefix that was held when reset was asserted is discarded. After reset, `in_ready` is 1.
- R2: A word with PO other than 9 or 1 yields a record in the cycle after it is accepted. That record has space 0 (plain), prefix 0, cause 0, and `out_word` equal to the word.
- R3: A word with PO 9 or 1 produces no record. Its record appears in the cycle after the next accepted word, whatever idle cycles lie between. The record has `out_prefix` = the held word and `out_word` = the following word.
- R4: For an opcode-9 prefix with bit 6 = 0, the space codes are as follows. Space 2 (reserved, 57-bit) applies when bit 32 is 0, whatever bit 7 and bits 8-31 hold. When bit 32 is 1: bit 7 = 1 gives space 5 (vector, extended), including all-zero bits 8-31. Otherwise, zero bits 8-31 give space 3 (scalar, extended) and nonzero bits give space 4 (single, extended).
- R5: For an opcode-9 prefix with bit 6 = 1, bit 32 does not matter. Bit 7 = 1 gives space 8 (vector, base). Bit 7 = 0 gives space 6 (reserved, 32-bit) when bits 8-31 are zero, and space 7 (single, base) otherwise.
- R6: Spaces 2, 4, 6 and 7 carry cause 1 (reserved). This cause has the highest priority.
- R7: If the word after any prefix has PO 1 or 9, the record carries cause 2 (stacked prefix), unless cause 1 applies. The block then expects a fresh word, so the next word is decoded on its own.
- R8: In space 8, an unrepeatable suffix carries cause 3 (unvectorisable) when neither cause 1 nor cause 2 applies. An unrepeatable suffix is PO 17, or PO 31 with XO 598, 146 or 178. The same words give cause 0 when they are plain or follow an opcode-1 prefix.
- R9: `out_class` classifies the base-opcode word (the plain word, or the suffix in spaces 1, 7 and 8). It is 4 (branch-conditional) for PO 16 or for PO 19 with XO 16 or 528. It is 2 (condition-register) for other PO 19 words. It is 3 (load/store) for PO 32-55, 58 or 62, and 1 (arithmetic/logical) for everything else. In all other spaces it is 0.
- R10: `out_illegal` is 1 exactly when `out_cause` is nonzero.
- R11: `in_ready` is 1 when no record is waiting or the record is being taken. While `out_valid` is 1 and `out_ready` is 0, the record holds steady and no word is accepted.
- R12: An opcode-1 prefix pairs with the next word as space 1 (wide-immediate). It carries cause 0 unless that word has PO 1 or 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Word accepted this cycle when valid |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_prefix | output | 32 | Held prefix word, zero for a plain word |
| out_word | output | 32 | Suffix word, or the plain word |
| out_space | output | 4 | Encoding space code |
| out_class | output | 3 | Class of the base-opcode word |
| out_illegal | output | 1 | Illegal-instruction flag |
| out_cause | output | 2 | Trap cause code |

## Verification
A wrong pairing state shows at the ports in the very next record. A missed hold turns a prefix into a plain record with prefix 0. A stale hold gives a plain word a nonzero prefix and a non-plain space. Because every word ends the pair state, a single slip misaligns all later records until a reset. A wrong space decision or cause priority shows as a wrong code in the record of the pair that exercises it. The table therefore walks each corner of every prefix bit pattern, and the directed tests cover stalls, idle gaps, reset inside a pair and the 96-bit sequence.

// File: rtl/vpfx_pkg.sv
// Shared widths, opcode constants and code types for the prefixed-instruction
// pre-decoder. Assumes 32-bit instruction words, MSB-0 bit numbering.
package vpfx_pkg;

    localparam int WORD_W = 32;
    localparam int PO_W   = 6;
    localparam int XO_W   = 10;
    localparam int XO_LSB = 1;
    localparam int SEL_W  = WORD_W - PO_W;      // prefix bits 6..31

    localparam logic [PO_W-1:0] VEC_PFX_PO  = 6'd9;
    localparam logic [PO_W-1:0] WIDE_PFX_PO = 6'd1;

    typedef enum logic [3:0] {
        SP_PLAIN   = 4'd0,
        SP_WIDE    = 4'd1,
        SP_RSV57   = 4'd2,
        SP_XSCALAR = 4'd3,
        SP_XSINGLE = 4'd4,
        SP_XVECTOR = 4'd5,
        SP_RSV32   = 4'd6,
        SP_BSINGLE = 4'd7,
        SP_BVECTOR = 4'd8
    } space_e;

    typedef enum logic [2:0] {
        CL_NONE   = 3'd0,
        CL_ALU    = 3'd1,
        CL_CRLOG  = 3'd2,
        CL_LDST   = 3'd3,
        CL_BRCOND = 3'd4
    } class_e;

    typedef enum logic [1:0] {
        CA_NONE     = 2'd0,
        CA_RESERVED = 2'd1,
        CA_STACKED  = 2'd2,
        CA_UNVEC    = 2'd3
    } cause_e;

    typedef enum logic {
        ST_WORD   = 1'b0,
        ST_SUFFIX = 1'b1
    } pair_state_e;

endpackage

// File: rtl/vpfx_pair_ctrl.sv
// Pairing control: decides whether an accepted word is a prefix to be held
// or completes a record. Assumes `take` is high only for an accepted word.
module vpfx_pair_ctrl
    import vpfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] hold_q,
    output logic              emit,
    output logic              pair
);

    pair_state_e       state_q;
    logic [PO_W-1:0]   po;
    logic              is_pfx;

    // Spot a prefix opcode in the offered word.
    always_comb begin
        po     = word[WORD_W-1 -: PO_W];
        is_pfx = (po == VEC_PFX_PO) || (po == WIDE_PFX_PO);
    end

    // A record leaves on every accepted word except a prefix taken while idle.
    always_comb begin
        pair = (state_q == ST_SUFFIX);
        emit = take && (pair || !is_pfx);
    end

    // Hold the prefix and step between the two waiting states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WORD;
            hold_q  <= '0;
        end else if (take) begin
            if (state_q == ST_WORD && is_pfx) begin
                state_q <= ST_SUFFIX;
                hold_q  <= word;
            end else begin
                state_q <= ST_WORD;
            end
        end
    end

endmodule

// File: rtl/vpfx_space_sort.sv
// Encoding-space sorter: maps the held prefix selector bits and the first
// suffix bit onto a space code. Purely combinational.
module vpfx_space_sort
    import vpfx_pkg::*;
(
    input  logic             wide_pfx,
    input  logic [SEL_W-1:0] sel,
    input  logic             sfx_msb,
    output space_e           space,
    output logic             reserved,
    output logic             base_sfx
);

    logic b6, b7, tail_nz;

    // Pull out the selector bits (MSB-0 bit 6, bit 7, bits 8-31).
    always_comb begin
        b6      = sel[SEL_W-1];
        b7      = sel[SEL_W-2];
        tail_nz = |sel[SEL_W-3:0];
    end

    // Decision tree over the prefix bits and suffix bit 32.
    always_comb begin
        if (wide_pfx)         space = SP_WIDE;
        else if (!b6) begin
            if (!sfx_msb)     space = SP_RSV57;
            else if (b7)      space = SP_XVECTOR;
            else if (tail_nz) space = SP_XSINGLE;
            else              space = SP_XSCALAR;
        end else begin
            if (b7)           space = SP_BVECTOR;
            else if (tail_nz) space = SP_BSINGLE;
            else              space = SP_RSV32;
        end
    end

    // Flag reserved areas and areas whose suffix uses the base opcode map.
    always_comb begin
        reserved = (space == SP_RSV57) || (space == SP_XSINGLE) ||
                   (space == SP_RSV32) || (space == SP_BSINGLE);
        base_sfx = (space == SP_WIDE) || (space == SP_BSINGLE) ||
                   (space == SP_BVECTOR);
    end

endmodule

// File: rtl/vpfx_suffix_screen.sv
// Suffix screen: coarse class of a base-map word, detection of words that
// must not be repeated, and detection of a prefix opcode in suffix position.
// Assumes the XO field sits at MSB-0 bits 21-30.
module vpfx_suffix_screen
    import vpfx_pkg::*;
#(
    parameter logic [PO_W-1:0] BC_PO      = 6'd16,
    parameter logic [PO_W-1:0] CRX_PO     = 6'd19,
    parameter logic [XO_W-1:0] BLR_XO     = 10'd16,
    parameter logic [XO_W-1:0] BCTR_XO    = 10'd528,
    parameter logic [PO_W-1:0] LDST_LO    = 6'd32,
    parameter logic [PO_W-1:0] LDST_HI    = 6'd55,
    parameter logic [PO_W-1:0] DS_LD_PO   = 6'd58,
    parameter logic [PO_W-1:0] DS_ST_PO   = 6'd62,
    parameter logic [PO_W-1:0] SYSCALL_PO = 6'd17,
    parameter logic [PO_W-1:0] XFORM_PO   = 6'd31,
    parameter int              N_XO       = 3,
    parameter logic [N_XO-1:0][XO_W-1:0] NOREP_XO = {10'd598, 10'd146, 10'd178}
) (
    input  logic [PO_W-1:0] po,
    input  logic [XO_W-1:0] xo,
    output class_e          cls,
    output logic            unvec,
    output logic            chain
);

    logic [N_XO-1:0] xo_hit;
    logic            is_br, is_cr, is_ls;

    // One comparator per unrepeatable extended opcode.
    for (genvar g = 0; g < N_XO; g++) begin : g_norep
        assign xo_hit[g] = (xo == NOREP_XO[g]);
    end

    // Class decision for a base-map word.
    always_comb begin
        is_br = (po == BC_PO) || ((po == CRX_PO) && ((xo == BLR_XO) || (xo == BCTR_XO)));
        is_cr = (po == CRX_PO) && !is_br;
        is_ls = ((po >= LDST_LO) && (po <= LDST_HI)) || (po == DS_LD_PO) || (po == DS_ST_PO);
        if (is_br)      cls = CL_BRCOND;
        else if (is_cr) cls = CL_CRLOG;
        else if (is_ls) cls = CL_LDST;
        else            cls = CL_ALU;
    end

    // Unrepeatable words and prefix opcodes in suffix position.
    always_comb begin
        unvec = (po == SYSCALL_PO) || ((po == XFORM_PO) && (|xo_hit));
        chain = (po == VEC_PFX_PO) || (po == WIDE_PFX_PO);
    end

endmodule

// File: rtl/vpfx_predecode.sv
// Top of the prefixed-instruction pre-decoder. Accepts words on a
// valid/ready handshake, pairs prefixes with their suffix, and registers one
// classified record per instruction. Assumes the consumer may stall freely.
module vpfx_predecode
    import vpfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_prefix,
    output logic [WORD_W-1:0] out_word,
    output logic [3:0]        out_space,
    output logic [2:0]        out_class,
    output logic              out_illegal,
    output logic [1:0]        out_cause
);

    logic              take, emit, pair;
    logic [WORD_W-1:0] held;
    space_e            sort_space;
    logic              sort_rsv, sort_base;
    class_e            scr_cls;
    logic              scr_unvec, scr_chain;

    logic [WORD_W-1:0] r_pfx;
    space_e            r_space;
    class_e            r_class;
    cause_e            r_cause;

    // Accept a word whenever the output slot is free or being drained.
    always_comb begin
        in_ready = !out_valid || out_ready;
        take     = in_valid && in_ready;
    end

    vpfx_pair_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .word   (in_word),
        .hold_q (held),
        .emit   (emit),
        .pair   (pair)
    );

    vpfx_space_sort u_sort (
        .wide_pfx (held[WORD_W-1 -: PO_W] == WIDE_PFX_PO),
        .sel      (held[SEL_W-1:0]),
        .sfx_msb  (in_word[WORD_W-1]),
        .space    (sort_space),
        .reserved (sort_rsv),
        .base_sfx (sort_base)
    );

    vpfx_suffix_screen u_screen (
        .po    (in_word[WORD_W-1 -: PO_W]),
        .xo    (in_word[XO_LSB +: XO_W]),
        .cls   (scr_cls),
        .unvec (scr_unvec),
        .chain (scr_chain)
    );

    // Assemble the record for the word being accepted, with cause priority.
    always_comb begin
        if (pair) begin
            r_pfx   = held;
            r_space = sort_space;
            r_class = sort_base ? scr_cls : CL_NONE;
            if (sort_rsv)                                  r_cause = CA_RESERVED;
            else if (scr_chain)                            r_cause = CA_STACKED;
            else if (sort_space == SP_BVECTOR && scr_unvec) r_cause = CA_UNVEC;
            else                                           r_cause = CA_NONE;
        end else begin
            r_pfx   = '0;
            r_space = SP_PLAIN;
            r_class = scr_cls;
            r_cause = CA_NONE;
        end
    end

    // Output record register with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_prefix  <= '0;
            out_word    <= '0;
            out_space   <= SP_PLAIN;
            out_class   <= CL_NONE;
            out_illegal <= 1'b0;
            out_cause   <= CA_NONE;
        end else if (emit) begin
            out_valid   <= 1'b1;
            out_prefix  <= r_pfx;
            out_word    <= in_word;
            out_space   <= r_space;
            out_class   <= r_class;
            out_illegal <= (r_cause != CA_NONE);
            out_cause   <= r_cause;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

endmodule

// File: rtl/vpfx_predecode_chk.sv
// Property checker for the pre-decoder, attached by bind. Observes ports only.
module vpfx_predecode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_prefix,
    input logic [31:0] out_word,
    input logic [3:0]  out_space,
    input logic [1:0]  out_cause,
    input logic        out_illegal
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) &&
        $stable(out_prefix) && $stable(out_space) && $stable(out_cause));

    // R11
    free_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R2
    plain_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_space == 4'd0 |-> out_prefix == 32'd0 && !out_illegal);

    // R3
    pair_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_space != 4'd0 |->
        (out_prefix[31:26] == 6'd9) || (out_prefix[31:26] == 6'd1));

    // R4
    rsv57_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_space == 4'd2 |-> !out_prefix[25] && !out_word[31]);

    // R5
    bvec_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_space == 4'd8 |-> out_prefix[25:24] == 2'b11);

    // R6
    reserved_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_space == 4'd2 || out_space == 4'd4 ||
                      out_space == 4'd6 || out_space == 4'd7)
        |-> out_cause == 2'd1);

    // R8
    unvec_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_cause == 2'd3 |-> out_space == 4'd8);

    // R10
    illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_illegal == (out_cause != 2'd0));

endmodule

bind vpfx_predecode vpfx_predecode_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_prefix  (out_prefix),
    .out_word    (out_word),
    .out_space   (out_space),
    .out_cause   (out_cause),
    .out_illegal (out_illegal)
);

// File: tb/tb_vpfx_predecode.sv
module tb_vpfx_predecode;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NV         = 37;

    // {has_prefix, prefix, word, space, class, cause}
    typedef struct packed {
        logic        hp;
        logic [31:0] pf;
        logic [31:0] wd;
        logic [3:0]  sp;
        logic [2:0]  cl;
        logic [1:0]  ca;
    } vec_t;

    localparam logic [73:0] VECS [NV] = '{
        {1'b0, 32'h00000000, 32'h38210001, 4'd0, 3'd1, 2'd0},  // R2 R9
        {1'b0, 32'h00000000, 32'h80010008, 4'd0, 3'd3, 2'd0},  // R2 R9
        {1'b0, 32'h00000000, 32'h7C0004AC, 4'd0, 3'd1, 2'd0},  // R8 plain ok
        {1'b0, 32'h00000000, 32'h4C000202, 4'd0, 3'd2, 2'd0},  // R9
        {1'b1, 32'h24000000, 32'h10000000, 4'd2, 3'd0, 2'd1},  // R4 R6
        {1'b1, 32'h25ABCDEF, 32'h38000000, 4'd2, 3'd0, 2'd1},  // R4
        {1'b1, 32'h24000000, 32'hA0000000, 4'd3, 3'd0, 2'd0},  // R4
        {1'b1, 32'h24000100, 32'hA0000000, 4'd4, 3'd0, 2'd1},  // R4 R6
        {1'b1, 32'h25000000, 32'hA0000000, 4'd5, 3'd0, 2'd0},  // R4 identity
        {1'b1, 32'h25123456, 32'hC4000000, 4'd5, 3'd0, 2'd0},  // R4
        {1'b1, 32'h26000000, 32'h38210001, 4'd6, 3'd0, 2'd1},  // R5 R6
        {1'b1, 32'h26000000, 32'hA0000000, 4'd6, 3'd0, 2'd1},  // R5
        {1'b1, 32'h26000001, 32'h38210001, 4'd7, 3'd1, 2'd1},  // R5 R6
        {1'b1, 32'h27000000, 32'h7C000214, 4'd8, 3'd1, 2'd0},  // R5
        {1'b1, 32'h27800000, 32'h41820008, 4'd8, 3'd4, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'h4C000020, 4'd8, 3'd4, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'h4C000420, 4'd8, 3'd4, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'h4C000202, 4'd8, 3'd2, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'hE8010000, 4'd8, 3'd3, 2'd0},  // R9 R5
        {1'b1, 32'h27000000, 32'hDC000000, 4'd8, 3'd3, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'hE0000000, 4'd8, 3'd1, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'hE4000000, 4'd8, 3'd1, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'hF8010000, 4'd8, 3'd3, 2'd0},  // R9
        {1'b1, 32'h27000000, 32'h44000002, 4'd8, 3'd1, 2'd3},  // R8
        {1'b1, 32'h27000000, 32'h7C0004AC, 4'd8, 3'd1, 2'd3},  // R8
        {1'b1, 32'h27000000, 32'h7C000124, 4'd8, 3'd1, 2'd3},  // R8
        {1'b1, 32'h27000000, 32'h7C000164, 4'd8, 3'd1, 2'd3},  // R8
        {1'b1, 32'h27000000, 32'h04000000, 4'd8, 3'd1, 2'd2},  // R7
        {1'b1, 32'h27000000, 32'h24000000, 4'd8, 3'd1, 2'd2},  // R7
        {1'b1, 32'h26000005, 32'h04000000, 4'd7, 3'd1, 2'd1},  // R6 over R7
        {1'b1, 32'h26000001, 32'h44000002, 4'd7, 3'd1, 2'd1},  // R6 over R8
        {1'b1, 32'h24000000, 32'h04000000, 4'd2, 3'd0, 2'd1},  // R6
        {1'b1, 32'h04000000, 32'h38210001, 4'd1, 3'd1, 2'd0},  // R12
        {1'b1, 32'h04001234, 32'h04000000, 4'd1, 3'd1, 2'd2},  // R12 R7
        {1'b1, 32'h04000000, 32'h24000000, 4'd1, 3'd1, 2'd2},  // R12 R7
        {1'b1, 32'h04000000, 32'h7C0004AC, 4'd1, 3'd1, 2'd0},  // R12 R8
        {1'b1, 32'h06FFFFFF, 32'h4C000420, 4'd1, 3'd4, 2'd0}   // R12 R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_prefix, out_word;
    logic [3:0]  out_space;
    logic [2:0]  out_class;
    logic        out_illegal;
    logic [1:0]  out_cause;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vpfx_predecode dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_prefix(out_prefix), .out_word(out_word), .out_space(out_space),
        .out_class(out_class), .out_illegal(out_illegal), .out_cause(out_cause)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one word at a negedge and hold it until accepted at a posedge.
    task automatic push(input logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic check_rec(input logic [31:0] pf, input logic [31:0] wd, input logic [3:0] sp,
                             input logic [2:0] cl, input logic [1:0] ca);
        @(negedge clk);
        check(out_valid == 1'b1, "R3 record valid", 32'(out_valid), 32'd1);
        check(out_prefix == pf, "R3 prefix field", out_prefix, pf);
        check(out_word == wd, "R3 word field", out_word, wd);
        check(out_space == sp, "R4/R5 space", 32'(out_space), 32'(sp));
        check(out_class == cl, "R9 class", 32'(out_class), 32'(cl));
        check(out_cause == ca, "R6/R7/R8 cause", 32'(out_cause), 32'(ca));
        check(out_illegal == (ca != 2'd0), "R10 illegal", 32'(out_illegal), 32'(ca != 2'd0));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: state after reset
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1 in_ready after reset", 32'(in_ready), 32'd1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            if (v.hp) begin
                push(v.pf);
                @(negedge clk);
                check(out_valid == 1'b0, "R3 no record for prefix", 32'(out_valid), 32'd0);
                push(v.wd);
                check_rec(v.pf, v.wd, v.sp, v.cl, v.ca);
            end else begin
                push(v.wd);
                check_rec(32'd0, v.wd, 4'd0, v.cl, 2'd0);
            end
        end

        // R3: idle gap between prefix and suffix
        push(32'h27000000);
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R3 idle gap no record", 32'(out_valid), 32'd0);
        end
        push(32'h38210001);
        check_rec(32'h27000000, 32'h38210001, 4'd8, 3'd1, 2'd0);

        // R1: reset inside a pair discards the held prefix
        push(32'h27000000);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        push(32'h38210001);
        check_rec(32'd0, 32'h38210001, 4'd0, 3'd1, 2'd0);

        // R7: 96-bit sequence, then the trailing word decoded alone
        push(32'h27000000);
        push(32'h04000000);
        check_rec(32'h27000000, 32'h04000000, 4'd8, 3'd1, 2'd2);
        push(32'h80010008);
        check_rec(32'd0, 32'h80010008, 4'd0, 3'd3, 2'd0);

        // R11: stall holds the record and blocks input
        @(negedge clk);
        out_ready = 1'b0;
        push(32'h38210001);
        @(negedge clk);
        check(in_ready == 1'b0, "R11 in_ready low on stall", 32'(in_ready), 32'd0);
        in_valid = 1'b1;
        in_word  = 32'h80010008;
        repeat (3) begin
            @(negedge clk);
            check(out_valid && out_word == 32'h38210001, "R11 record held",
                  out_word, 32'h38210001);
            check(in_ready == 1'b0, "R11 no accept during stall", 32'(in_ready), 32'd0);
        end
        out_ready = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        check(out_valid && out_word == 32'h80010008, "R11 next word after release",
              out_word, 32'h80010008);
        @(negedge clk);
        check(out_valid == 1'b0, "R11 drained", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule